// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, given as a segment number and an offset within that segment, into a physical address. Two configuration registers describe the current segment table: its word address in memory and the number of segments it holds. For each accepted request the unit first compares the segment number with the segment count. An out-of-range number is refused at once and the table is not touched. Otherwise one descriptor word is read through a simple memory read port, and the validity, bounds and access rights are checked against it.

The response is either the physical address, formed as the descriptor base plus the offset, or a trap with a three-bit cause code. Only one request is handled at a time. `req_ready` is low while a descriptor fetch is outstanding, and every request gets exactly one single-cycle response pulse.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_rd` are 0, and both the table base and the segment count are 0, so any request traps with cause 3'd1.
- R2: A cycle with `cfg_we`=1 loads `cfg_wdata` into the table base when `cfg_sel`=0, or its low SEG_W+1 bits into the segment count when `cfg_sel`=1. A write in the same cycle as a request is accepted, or during that request's fetch, does not change how that request is handled.
- R3: A segment number not below the segment count traps with cause 3'd1. `rsp_valid` rises in the cycle after acceptance, and `mem_rd` is never asserted for that request.
- R4: For an in-range segment s, `mem_rd` stays high with `mem_addr` = table base + s, held stable, until the cycle `mem_rvalid` is 1. The descriptor word carries the base in bits [PA_W-1:0], the limit in the next OFF_W bits, and then the valid, read, write and execute bits, in that order going up.
- R5: A descriptor whose valid bit is 0 traps with cause 3'd2.
- R6: An offset greater than or equal to the descriptor limit traps with cause 3'd3. An offset equal to the limit faults.
- R7: Access code 0 (read), 1 (write) or 2 (execute) needs the matching descriptor right bit. Code 3 is always refused. A refusal traps with cause 3'd4.
- R8: When several checks fail, the reported cause is the lowest-numbered one: range, then validity, then limit, then rights.
- R9: When every check passes, `rsp_trap` is 0, `rsp_cause` is 0 and `rsp_paddr` equals base + offset modulo 2^PA_W. On a trap `rsp_paddr` is 0.
- R10: `req_ready` is 0 from the acceptance of an in-range request until its response. `rsp_valid` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the segment count |
| cfg_wdata | input | PA_W | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd | output | 1 | Descriptor read request, held until data returns |
| mem_addr | output | PA_W | Descriptor word address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | PA_W+OFF_W+4 | Descriptor word |
| rsp_valid | output | 1 | Response pulse |
| rsp_trap | output | 1 | Response is a trap |
| rsp_cause | output | 3 | Trap cause, 0 when no trap |
| rsp_paddr | output | PA_W | Physical address, 0 on a trap |

## Verification
Two cases can land in the same cycle. A configuration write can coincide with the acceptance of a request, and a table base write can occur while a descriptor fetch is outstanding. The bench shrinks the segment count in the very cycle a request for segment 3 is accepted, and expects the invalid-descriptor cause rather than the range cause. It then moves the table base during a fetch and expects both the old fetch address and a normal translation. A second overlap happens inside the checker, where one descriptor fails several checks at once. Vectors that are both invalid and over limit, or both over limit and without rights, are judged by the single cause code returned.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_RANGE   = 3'd1,
    CAUSE_INVALID = 3'd2,
    CAUSE_LIMIT   = 3'd3,
    CAUSE_RIGHTS  = 3'd4
  } seg_cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } seg_acc_e;

  typedef enum logic {
    ST_IDLE,
    ST_FETCH
  } seg_state_e;

endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs #(
  parameter int PA_W  = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  output logic [PA_W-1:0]  tbl_base,
  output logic [LEN_W-1:0] tbl_len
);

  logic [PA_W-1:0]  base_q, base_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             base_en, len_en;

  always_comb begin
    base_en = cfg_we && !cfg_sel;
    len_en  = cfg_we && cfg_sel;
    base_d  = cfg_wdata;
    len_d   = cfg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (len_en)  len_q  <= len_d;
    end
  end

  assign tbl_base = base_q;
  assign tbl_len  = len_q;

  // R2: the segment count only moves on a count write
  a_r2_len_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel) |=> $stable(tbl_len));

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 16,
  parameter int OFF_W = 12,
  parameter int ENT_W = PA_W + OFF_W + 4
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  output logic [2:0]       cause,
  output logic [PA_W-1:0]  paddr
);

  localparam int LIM_LO = PA_W;
  localparam int V_BIT  = PA_W + OFF_W;

  logic [PA_W-1:0]  seg_base;
  logic [OFF_W-1:0] seg_limit;
  logic             seg_ok, rd_ok, wr_ok, ex_ok, rights_ok;
  seg_cause_e       cause_c;

  always_comb begin
    seg_base  = entry[PA_W-1:0];
    seg_limit = entry[LIM_LO +: OFF_W];
    seg_ok    = entry[V_BIT];
    rd_ok     = entry[V_BIT+1];
    wr_ok     = entry[V_BIT+2];
    ex_ok     = entry[V_BIT+3];

    case (seg_acc_e'(acc))
      ACC_READ:  rights_ok = rd_ok;
      ACC_WRITE: rights_ok = wr_ok;
      ACC_EXEC:  rights_ok = ex_ok;
      default:   rights_ok = 1'b0;
    endcase

    if (!seg_ok)                cause_c = CAUSE_INVALID;
    else if (off >= seg_limit)  cause_c = CAUSE_LIMIT;
    else if (!rights_ok)        cause_c = CAUSE_RIGHTS;
    else                        cause_c = CAUSE_NONE;

    cause = cause_c;
    paddr = (cause_c == CAUSE_NONE)
          ? seg_base + {{(PA_W-OFF_W){1'b0}}, off}
          : '0;
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 16,
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  localparam int LEN_W = SEG_W + 1,
  localparam int ENT_W = PA_W + OFF_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             mem_rd,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_trap,
  output logic [2:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic [PA_W-1:0]  tbl_base;
  logic [LEN_W-1:0] tbl_len;

  seg_xlate_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tbl_base  (tbl_base),
    .tbl_len   (tbl_len)
  );

  seg_state_e       state_q, state_d;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic [PA_W-1:0]  ent_addr_q, ent_addr_d;
  logic             req_ld;

  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_trap_q, rsp_trap_d;
  logic [2:0]       rsp_cause_q, rsp_cause_d;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  logic             rsp_ld;

  logic             accept, range_bad;
  logic [2:0]       chk_cause;
  logic [PA_W-1:0]  chk_paddr;

  seg_xlate_check #(.PA_W(PA_W), .OFF_W(OFF_W), .ENT_W(ENT_W)) check_i (
    .entry (mem_rdata),
    .off   (off_q),
    .acc   (acc_q),
    .cause (chk_cause),
    .paddr (chk_paddr)
  );

  // next-state logic
  always_comb begin
    accept      = req_valid && (state_q == ST_IDLE);
    range_bad   = ({1'b0, req_seg} >= tbl_len);
    state_d     = state_q;
    req_ld      = 1'b0;
    ent_addr_d  = tbl_base + {{(PA_W-SEG_W){1'b0}}, req_seg};
    rsp_valid_d = 1'b0;
    rsp_ld      = 1'b0;
    rsp_trap_d  = rsp_trap_q;
    rsp_cause_d = rsp_cause_q;
    rsp_paddr_d = rsp_paddr_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (range_bad) begin
            rsp_valid_d = 1'b1;
            rsp_ld      = 1'b1;
            rsp_trap_d  = 1'b1;
            rsp_cause_d = CAUSE_RANGE;
            rsp_paddr_d = '0;
          end else begin
            req_ld  = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (mem_rvalid) begin
          rsp_valid_d = 1'b1;
          rsp_ld      = 1'b1;
          rsp_trap_d  = (chk_cause != CAUSE_NONE);
          rsp_cause_d = chk_cause;
          rsp_paddr_d = chk_paddr;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      off_q       <= '0;
      acc_q       <= '0;
      ent_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_trap_q  <= 1'b0;
      rsp_cause_q <= '0;
      rsp_paddr_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (req_ld) begin
        off_q      <= req_off;
        acc_q      <= req_acc;
        ent_addr_q <= ent_addr_d;
      end
      if (rsp_ld) begin
        rsp_trap_q  <= rsp_trap_d;
        rsp_cause_q <= rsp_cause_d;
        rsp_paddr_q <= rsp_paddr_d;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_rd    = (state_q == ST_FETCH);
  assign mem_addr  = ent_addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_trap  = rsp_trap_q;
  assign rsp_cause = rsp_cause_q;
  assign rsp_paddr = rsp_paddr_q;

  // R3: out-of-range segment answers next cycle, with no table read
  a_r3_no_fetch_on_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len))
      |=> (!mem_rd && rsp_valid && rsp_cause == 3'd1));

  // R4: read request held with a stable address until data arrives
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  // R9: a trap never carries an address
  a_r9_trap_zero_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> (rsp_paddr == '0));

  // R8: cause code is non-zero exactly on traps
  a_r8_cause_iff_trap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_trap == (rsp_cause != 3'd0)));

  // R10: no new request taken while a fetch is outstanding
  a_r10_busy_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);

endmodule

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;

  localparam int PA_W  = 16;
  localparam int SEG_W = 4;
  localparam int OFF_W = 12;
  localparam int ENT_W = PA_W + OFF_W + 4;
  localparam logic [PA_W-1:0] TBL0 = 16'h0100;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we, cfg_sel;
  logic [PA_W-1:0]  cfg_wdata;
  logic             req_valid, req_ready;
  logic [SEG_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  logic [1:0]       req_acc;
  logic             mem_rd;
  logic [PA_W-1:0]  mem_addr;
  logic             mem_rvalid;
  logic [ENT_W-1:0] mem_rdata;
  logic             rsp_valid, rsp_trap;
  logic [2:0]       rsp_cause;
  logic [PA_W-1:0]  rsp_paddr;

  int checks = 0;
  int errors = 0;
  int fetch_cnt = 0;
  logic [PA_W-1:0] last_addr;
  logic done = 1'b0;

  always #2 clk = ~clk;

  seg_xlate_unit #(.PA_W(PA_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  // descriptor: {x, w, r, v, limit, base}
  function automatic logic [ENT_W-1:0] mk_ent(input logic [15:0] b, input logic [11:0] l,
                                             input logic v, input logic r,
                                             input logic w, input logic x);
    return {x, w, r, v, l, b};
  endfunction

  logic [ENT_W-1:0] tbl [16];

  function automatic logic [ENT_W-1:0] lookup(input logic [PA_W-1:0] a);
    if (a >= TBL0 && a < TBL0 + 16'd16) return tbl[a - TBL0];
    return '0;
  endfunction

  // memory model: one cycle latency, data valid for one cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_rd && !mem_rvalid;
      mem_rdata  <= lookup(mem_addr);
      if (mem_rd && !mem_rvalid) begin
        fetch_cnt <= fetch_cnt + 1;
        last_addr <= mem_addr;
      end
    end
  end

  // {seg, off, acc, trap, cause, paddr}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {4'd0, 12'h0FF, 2'd0, 1'b0, 3'd0, 16'h10FF},  // R6 limit-1 passes, R9
    {4'd0, 12'h100, 2'd0, 1'b1, 3'd3, 16'h0000},  // R6 offset equal to limit
    {4'd0, 12'h010, 2'd1, 1'b1, 3'd4, 16'h0000},  // R7 write on read-only
    {4'd1, 12'h7FF, 2'd1, 1'b0, 3'd0, 16'h27FF},  // R7 write allowed
    {4'd1, 12'h005, 2'd2, 1'b1, 3'd4, 16'h0000},  // R7 exec refused
    {4'd2, 12'h03F, 2'd2, 1'b0, 3'd0, 16'h303F},  // R7 exec-only segment
    {4'd2, 12'h000, 2'd0, 1'b1, 3'd4, 16'h0000},  // R7 read refused
    {4'd3, 12'h000, 2'd0, 1'b1, 3'd2, 16'h0000},  // R5 invalid
    {4'd3, 12'h020, 2'd1, 1'b1, 3'd2, 16'h0000},  // R8 invalid beats limit
    {4'd4, 12'h123, 2'd0, 1'b0, 3'd0, 16'h0023},  // R9 wraps modulo
    {4'd4, 12'h010, 2'd3, 1'b1, 3'd4, 16'h0000},  // R7 reserved code
    {4'd5, 12'h000, 2'd0, 1'b1, 3'd3, 16'h0000},  // R6 zero limit
    {4'd6, 12'h000, 2'd0, 1'b1, 3'd1, 16'h0000},  // R3 seg equal to count
    {4'd1, 12'h900, 2'd3, 1'b1, 3'd3, 16'h0000},  // R8 limit beats rights
    {4'd15, 12'h001, 2'd0, 1'b1, 3'd1, 16'h0000}  // R3 top segment
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic sel, input logic [PA_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // waits for the response after an acceptance edge; called at the first negedge after it
  task automatic wait_rsp(output int lat);
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_req(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                        input logic [1:0] a, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(lat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, fc;
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    tbl[0] = mk_ent(16'h1000, 12'h100, 1, 1, 0, 0);
    tbl[1] = mk_ent(16'h2000, 12'h800, 1, 1, 1, 0);
    tbl[2] = mk_ent(16'h3000, 12'h040, 1, 0, 0, 1);
    tbl[3] = mk_ent(16'h4000, 12'h010, 0, 1, 1, 1);
    tbl[4] = mk_ent(16'hFF00, 12'hFFF, 1, 1, 1, 1);
    tbl[5] = mk_ent(16'h5000, 12'h000, 1, 1, 1, 1);
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
    req_valid = 0; req_seg = '0; req_off = '0; req_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_rd", mem_rd, 0);
    fc = fetch_cnt;
    do_req(4'd0, 12'h0, 2'd0, lat);
    check("R1 zero count traps range", rsp_cause, 3'd1);
    check("R1 no fetch after reset", fetch_cnt, fc);

    wr_cfg(1'b0, TBL0);
    wr_cfg(1'b1, 16'd6);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      bit in_range;
      v = VEC[i];
      in_range = (v[37:34] < 4'd6);
      fc = fetch_cnt;
      do_req(v[37:34], v[33:22], v[21:20], lat);
      check($sformatf("R9 vec%0d valid", i), rsp_valid, 1);
      check($sformatf("R8 vec%0d trap", i), rsp_trap, v[19]);
      check($sformatf("R8 vec%0d cause", i), rsp_cause, v[18:16]);
      check($sformatf("R9 vec%0d paddr", i), rsp_paddr, v[15:0]);
      if (in_range) begin
        check($sformatf("R4 vec%0d one fetch", i), fetch_cnt, fc + 1);
        check($sformatf("R4 vec%0d fetch addr", i), last_addr, TBL0 + {12'h0, v[37:34]});
      end else begin
        check($sformatf("R3 vec%0d no fetch", i), fetch_cnt, fc);
        check($sformatf("R3 vec%0d latency", i), lat, 1);
      end
      @(negedge clk);
      check($sformatf("R10 vec%0d single pulse", i), rsp_valid, 0);
    end

    // R10 busy while fetching
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'd1; req_off = 12'h001; req_acc = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 ready low in fetch", req_ready, 0);
    check("R4 mem_rd high in fetch", mem_rd, 1);
    wait_rsp(lat);
    check("R10 response latency", lat, 3);
    check("R9 read pass paddr", rsp_paddr, 16'h2001);

    // R2 count write in the acceptance cycle uses the old count
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'd2;
    req_valid = 1'b1; req_seg = 4'd3; req_off = 12'h0; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    wait_rsp(lat);
    check("R2 same-cycle write uses old count", rsp_cause, 3'd2);
    do_req(4'd3, 12'h0, 2'd0, lat);
    check("R2 new count applies next", rsp_cause, 3'd1);
    do_req(4'd1, 12'h0, 2'd0, lat);
    check("R2 below new count passes", rsp_paddr, 16'h2000);
    wr_cfg(1'b1, 16'd6);

    // R2 base write during a fetch does not move it
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'd0; req_off = 12'h010; req_acc = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0200;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_rsp(lat);
    check("R2 fetch address kept", last_addr, TBL0);
    check("R2 translation kept", rsp_paddr, 16'h1010);
    do_req(4'd0, 12'h010, 2'd0, lat);
    check("R2 new base applies next", last_addr, 16'h0200);
    check("R5 unmapped area reads invalid", rsp_cause, 3'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule